// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Tracer

This block models the bookkeeping of a direct-mapped, write-back, write-allocate cache without moving any data. Each line keeps a tag, a valid flag and a dirty flag. Byte addresses arrive with a read/write flag over a valid/ready handshake. For every accepted access the block emits one classified event carrying the full address and its tag, index and offset fields. Running hit, miss and write-back totals are kept beside it.

When a miss lands on a line that is valid and dirty, the block first reports the eviction as a write-back event, then reports the miss itself on the next clock. The input is held off while this happens. Line count and block size are parameters. The two intended settings are eight lines of 4-byte blocks and four lines of 8-byte blocks. A bench can feed it an address trace and read off hit and miss rates for either geometry.

Top module: `dm_wb_cache_tracer`

## Requirements
- R1: An address splits into offset (the low log2(BLOCK_BYTES) bits), index (the next log2(LINES) bits) and tag (all remaining upper bits). Every access event reports the full address together with these three fields.
- R2: An access hits only when the line selected by its index is valid and holds the same tag. Any other access misses.
- R3: Each accepted access produces exactly one access event, with evt_kind 0 for a read hit, 1 for a read miss, 2 for a write hit and 3 for a write miss. The event is valid in the cycle after the accepting clock edge, or one cycle later when a write-back precedes it. evt_kind never exceeds 4.
- R4: A miss allocates the line: it stores the new tag and sets valid. A write miss marks the line dirty, a read miss leaves it clean, and a write hit marks it dirty.
- R5: A miss on a valid dirty line first emits an event with evt_kind 4 in the cycle after acceptance. That event carries the evicted tag, the same index, offset 0 and the address {evicted tag, index, zero offset}. The miss event follows on the next cycle, and req_ready is low while the write-back event is out.
- R6: A miss on an invalid line, or on a valid clean line, emits no write-back event.
- R7: hit_count, miss_count and wb_count each rise by one in the same cycle as the event of their kind is valid, and hold their value otherwise.
- R8: A synchronous reset clears every valid and dirty flag, zeroes all three counters and clears evt_valid. After reset, req_ready is high.
- R9: Both geometries, eight lines of 4-byte blocks and four lines of 8-byte blocks, are reached through the LINES and BLOCK_BYTES parameters alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| evt_valid | output | 1 | Event record valid this cycle |
| evt_kind | output | 3 | 0 read hit, 1 read miss, 2 write hit, 3 write miss, 4 write-back |
| evt_addr | output | ADDR_W | Address the event refers to |
| evt_index | output | IDX_W | Index field of evt_addr |
| evt_tag | output | TAG_W | Tag field of evt_addr |
| evt_offset | output | OFF_W | Offset field of evt_addr |
| hit_count | output | CNT_W | Hits so far |
| miss_count | output | CNT_W | Misses so far |
| wb_count | output | CNT_W | Write-backs so far |

## Verification
The bench drives a request on a falling edge, and the request is accepted on the next rising edge. An access event without eviction is due one cycle after that edge, so the bench samples it at the following falling edge. When an eviction is expected, the write-back event is sampled at that falling edge together with a low req_ready, and the miss event is sampled one falling edge later. The counters are compared at the same sampling points as the event they account for, since they are updated by the same edge that registers the event.

// File: rtl/dm_wb_cache_tracer.sv
module dm_wb_cache_tracer #(
  parameter int ADDR_W      = 32,
  parameter int LINES       = 8,
  parameter int BLOCK_BYTES = 4,
  parameter int CNT_W       = 32,
  localparam int OFF_W = $clog2(BLOCK_BYTES),
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              evt_valid,
  output logic [2:0]        evt_kind,
  output logic [ADDR_W-1:0] evt_addr,
  output logic [IDX_W-1:0]  evt_index,
  output logic [TAG_W-1:0]  evt_tag,
  output logic [OFF_W-1:0]  evt_offset,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  wb_count
);

  localparam logic [2:0] K_RD_HIT  = 3'd0;
  localparam logic [2:0] K_RD_MISS = 3'd1;
  localparam logic [2:0] K_WR_HIT  = 3'd2;
  localparam logic [2:0] K_WR_MISS = 3'd3;
  localparam logic [2:0] K_EVICT   = 3'd4;

  logic [TAG_W-1:0]  tags [LINES];
  logic [LINES-1:0]  vld, drt;
  logic              pend, p_write;
  logic [ADDR_W-1:0] p_addr;

  wire [IDX_W-1:0] r_idx  = req_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] r_tag  = req_addr[ADDR_W-1 -: TAG_W];
  wire             accept = req_valid && !pend;
  wire             hit    = vld[r_idx] && (tags[r_idx] == r_tag);
  wire             evict  = !hit && vld[r_idx] && drt[r_idx];

  assign req_ready  = !pend;
  assign evt_offset = evt_addr[OFF_W-1:0];
  assign evt_index  = evt_addr[OFF_W +: IDX_W];
  assign evt_tag    = evt_addr[ADDR_W-1 -: TAG_W];

  always_ff @(posedge clk) begin
    if (accept && !hit) tags[r_idx] <= r_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld        <= '0;
      drt        <= '0;
      pend       <= 1'b0;
      p_write    <= 1'b0;
      p_addr     <= '0;
      evt_valid  <= 1'b0;
      evt_kind   <= K_RD_HIT;
      evt_addr   <= '0;
      hit_count  <= '0;
      miss_count <= '0;
      wb_count   <= '0;
    end else begin
      evt_valid <= 1'b0;
      if (pend) begin
        evt_valid  <= 1'b1;
        evt_kind   <= p_write ? K_WR_MISS : K_RD_MISS;
        evt_addr   <= p_addr;
        miss_count <= miss_count + CNT_W'(1);
        pend       <= 1'b0;
      end else if (accept) begin
        evt_valid <= 1'b1;
        if (evict) begin
          evt_kind <= K_EVICT;
          evt_addr <= {tags[r_idx], r_idx, {OFF_W{1'b0}}};
          wb_count <= wb_count + CNT_W'(1);
          pend     <= 1'b1;
          p_addr   <= req_addr;
          p_write  <= req_write;
        end else begin
          evt_addr <= req_addr;
          if (hit) begin
            evt_kind  <= req_write ? K_WR_HIT : K_RD_HIT;
            hit_count <= hit_count + CNT_W'(1);
          end else begin
            evt_kind   <= req_write ? K_WR_MISS : K_RD_MISS;
            miss_count <= miss_count + CNT_W'(1);
          end
        end
        if (!hit) begin
          vld[r_idx] <= 1'b1;
          drt[r_idx] <= req_write;
        end else if (req_write) begin
          drt[r_idx] <= 1'b1;
        end
      end
    end
  end

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (!evt_valid && req_ready && hit_count == '0 && miss_count == '0 && wb_count == '0));

  a_r3_kind_range: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> (evt_kind <= K_EVICT));

  a_r5_stall_on_evict: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_kind == K_EVICT) |-> !req_ready);

  a_r5_miss_follows: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_kind == K_EVICT) |=>
      (evt_valid && (evt_kind == K_RD_MISS || evt_kind == K_WR_MISS) &&
       evt_index == $past(evt_index) && evt_tag != $past(evt_tag)));

  a_r5_evict_zero_offset: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_kind == K_EVICT) |-> (evt_offset == '0));

  a_r7_hit_count_step: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && (evt_kind == K_RD_HIT || evt_kind == K_WR_HIT)) |->
      (hit_count == $past(hit_count) + CNT_W'(1)));

  a_r7_idle_counts_hold: assert property (@(posedge clk) disable iff (rst)
    (!evt_valid && !$past(rst)) |->
      ($stable(hit_count) && $stable(miss_count) && $stable(wb_count)));

endmodule

// File: tb/dm_wb_cache_tracer_tb.sv
`timescale 1ns/1ps
module dm_wb_cache_tracer_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        a_rv, a_wr, a_rr, a_ev;
  logic [31:0] a_ad, a_ea, a_hc, a_mc, a_wc;
  logic [2:0]  a_k;
  logic [2:0]  a_ix;
  logic [26:0] a_tg;
  logic [1:0]  a_of;

  logic        b_rv, b_wr, b_rr, b_ev;
  logic [31:0] b_ad, b_ea, b_hc, b_mc, b_wc;
  logic [2:0]  b_k;
  logic [1:0]  b_ix;
  logic [26:0] b_tg;
  logic [2:0]  b_of;

  dm_wb_cache_tracer #(.LINES(8), .BLOCK_BYTES(4)) u_dut (
    .clk(clk), .rst(rst), .req_valid(a_rv), .req_ready(a_rr), .req_addr(a_ad),
    .req_write(a_wr), .evt_valid(a_ev), .evt_kind(a_k), .evt_addr(a_ea),
    .evt_index(a_ix), .evt_tag(a_tg), .evt_offset(a_of),
    .hit_count(a_hc), .miss_count(a_mc), .wb_count(a_wc));

  dm_wb_cache_tracer #(.LINES(4), .BLOCK_BYTES(8)) u_dut_b (
    .clk(clk), .rst(rst), .req_valid(b_rv), .req_ready(b_rr), .req_addr(b_ad),
    .req_write(b_wr), .evt_valid(b_ev), .evt_kind(b_k), .evt_addr(b_ea),
    .evt_index(b_ix), .evt_tag(b_tg), .evt_offset(b_of),
    .hit_count(b_hc), .miss_count(b_mc), .wb_count(b_wc));

  int n_chk = 0, n_bad = 0;
  logic [31:0] mt [2][8];
  bit mv [2][8];
  bit md [2][8];
  int eh [2], em [2], ew [2];

  logic        s_ev, s_rdy;
  logic [2:0]  s_k;
  logic [31:0] s_ea, s_ix, s_tg, s_of, s_hc, s_mc, s_wc;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic snap(int c);
    if (c == 0) begin
      s_ev = a_ev; s_rdy = a_rr; s_k = a_k; s_ea = a_ea;
      s_ix = 32'(a_ix); s_tg = 32'(a_tg); s_of = 32'(a_of);
      s_hc = a_hc; s_mc = a_mc; s_wc = a_wc;
    end else begin
      s_ev = b_ev; s_rdy = b_rr; s_k = b_k; s_ea = b_ea;
      s_ix = 32'(b_ix); s_tg = 32'(b_tg); s_of = 32'(b_of);
      s_hc = b_hc; s_mc = b_mc; s_wc = b_wc;
    end
  endtask

  task automatic chk_counts(int c);
    chk("R7", "hit_count", s_hc, 32'(eh[c]));
    chk("R7", "miss_count", s_mc, 32'(em[c]));
    chk("R7", "wb_count", s_wc, 32'(ew[c]));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; a_rv = 0; b_rv = 0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 2; c++) begin
      eh[c] = 0; em[c] = 0; ew[c] = 0;
      for (int i = 0; i < 8; i++) begin mv[c][i] = 0; md[c][i] = 0; mt[c][i] = '0; end
    end
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      snap(c);
      chk("R8", "evt_valid after reset", 32'(s_ev), 32'd0);
      chk("R8", "req_ready after reset", 32'(s_rdy), 32'd1);
      chk_counts(c);
    end
  endtask

  task automatic access(int c, logic [31:0] addr, bit wr);
    int offw, idxw, idx;
    logic [31:0] tag, off, wba;
    bit hit, wb;
    offw = (c == 0) ? 2 : 3;
    idxw = (c == 0) ? 3 : 2;
    off  = addr & ((32'd1 << offw) - 1);
    idx  = int'((addr >> offw) & ((32'd1 << idxw) - 1));
    tag  = addr >> (offw + idxw);
    hit  = mv[c][idx] && mt[c][idx] == tag;
    wb   = !hit && mv[c][idx] && md[c][idx];
    wba  = (mt[c][idx] << (offw + idxw)) | (32'(idx) << offw);
    if (!hit) begin mt[c][idx] = tag; mv[c][idx] = 1; md[c][idx] = wr; end
    else if (wr) md[c][idx] = 1;

    @(negedge clk);
    if (c == 0) begin a_rv = 1; a_ad = addr; a_wr = wr; end
    else begin b_rv = 1; b_ad = addr; b_wr = wr; end
    @(negedge clk);
    a_rv = 0; b_rv = 0;
    if (wb) begin
      ew[c]++;
      snap(c);
      chk("R5", "evict valid", 32'(s_ev), 32'd1);
      chk("R5", "evict kind", 32'(s_k), 32'd4);
      chk("R5", "evict addr", s_ea, wba);
      chk("R5", "evict tag", s_tg, wba >> (offw + idxw));
      chk("R5", "evict index", s_ix, 32'(idx));
      chk("R5", "evict offset", s_of, 32'd0);
      chk("R5", "ready low during evict", 32'(s_rdy), 32'd0);
      chk_counts(c);
      @(negedge clk);
    end
    if (hit) eh[c]++; else em[c]++;
    snap(c);
    chk("R3", "event valid", 32'(s_ev), 32'd1);
    chk(hit ? "R2" : "R4", "kind", 32'(s_k), {30'd0, wr, !hit});
    chk("R1", "addr", s_ea, addr);
    chk("R1", "tag", s_tg, tag);
    chk("R1", "index", s_ix, 32'(idx));
    chk("R1", "offset", s_of, off);
    if (!wb) chk("R6", "no evict before miss", 32'(s_wc), 32'(ew[c]));
    chk_counts(c);
    chk("R9", "ready after event", 32'(s_rdy), 32'd1);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R3 watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    a_rv = 0; a_wr = 0; a_ad = '0;
    b_rv = 0; b_wr = 0; b_ad = '0;
    void'($urandom(32'd20240611));
    do_reset();
    for (int c = 0; c < 2; c++) begin
      access(c, 32'h0000_0104, 0);
      access(c, 32'h0000_0105, 1);
      access(c, 32'h0000_0106, 0);
      access(c, 32'h0010_0104, 0);
      access(c, 32'h0010_0104, 1);
      access(c, 32'h0020_0107, 0);
      access(c, 32'h0020_0107, 1);
      access(c, 32'h0030_0104, 1);
      access(c, 32'h0040_0100, 1);
      access(c, 32'h0050_0100, 0);
    end
    do_reset();
    for (int c = 0; c < 2; c++) access(c, 32'h0030_0104, 0);
    for (int c = 0; c < 2; c++) begin
      for (int n = 0; n < 400; n++) begin
        logic [31:0] ad;
        ad = 32'h0000_1000 + ($urandom % 96);
        if ($urandom % 4 == 0) ad = ad + 32'h0001_0000;
        access(c, ad, bit'($urandom % 2));
      end
    end
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      snap(c);
      chk("R3", "idle no event", 32'(s_ev), 32'd0);
      chk_counts(c);
    end
    summary();
  end

endmodule